// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that computes each output without any multiplier. A new sample enters a tap history, and then the filter walks through the bit positions of every stored sample, one position per clock, starting with the least significant bit. In each cycle the current bit of every tap forms an address. Each group of four taps has its own small precomputed table. An entry in that table is the sum of the coefficients whose address bit is set. The group results are added, and a shift-accumulator weights each cycle's sum by the power of two of its bit position. The sum from the final cycle, which holds the sign bits, is subtracted instead of added.

A caller offers a sample with a one-cycle start strobe while the filter is idle. The filter stays busy for one clock per sample bit. It then presents the filtered value with a one-cycle valid pulse, and in that same cycle it becomes ready for the next sample. The coefficients are fixed at build time.

Top module: `daf_fir`

## Requirements
- R1: After reset, busy_o and y_valid_o are 0, y_o is 0, and every tap history entry is zero.
- R2: A start_i pulse while busy_o is 0 accepts sample_i at that rising edge, and busy_o is 1 from the next cycle.
- R3: y_valid_o is 1 for exactly one cycle, starting at the B-th rising edge after the accepting edge (B = 12 by default). busy_o falls at that same edge and stays 1 in every cycle before it.
- R4: y_o equals the sum over k of h[k]*x[n-k], where x[n] is the newest accepted sample and unfilled history counts as zero. The default coefficients are h = 5, -12, 37, 101, 88, -29, 14, -3 for k = 0..7, and y_o is a 24-bit two's complement value.
- R5: A start_i pulse while busy_o is 1 is ignored: that sample never enters the history, and the run in progress gives the same result.
- R6: Samples are B-bit two's complement, with the top bit weighted -2^(B-1). The most negative value -2048 and the most positive value 2047 filter exactly.
- R7: y_o keeps its value in every cycle where y_valid_o is 0.
- R8: A start_i pulse during the y_valid_o cycle is accepted, so outputs can follow one another every B+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample offer strobe |
| sample_i | input | 12 | Two's complement input sample |
| busy_o | output | 1 | A bit-serial run is in progress |
| y_valid_o | output | 1 | One-cycle pulse: y_o is new |
| y_o | output | 24 | Filtered output, two's complement |

## Verification
A positive unit impulse followed by zeros makes each output equal one coefficient in turn. This shows that every table entry is addressed by the correct tap and that taps are not swapped. An impulse of -2048, and long runs of -2048 and of 2047, separate a correct negative weight on the sign-bit slice from an accumulator that adds it, and they push the output to its largest magnitude. An alternating extreme pattern and a long pseudo-random sweep test sums across both groups and all bit positions. Spurious strobes issued mid-run, followed by comparison against a history that excludes them, show whether a busy-time start is really ignored.

// File: rtl/daf_pkg.sv
package daf_pkg;

    // Fixed tap weights; indices past the default set follow a folded formula.
    function automatic int coef_at(input int k);
        case (k)
            0: return 5;
            1: return -12;
            2: return 37;
            3: return 101;
            4: return 88;
            5: return -29;
            6: return 14;
            7: return -3;
            default: return ((k * 29) % 61) - 30;
        endcase
    endfunction

endpackage

// File: rtl/daf_subtable.sv
module daf_subtable #(
    parameter int BASE  = 0,
    parameter int GROUP = 4,
    parameter int TW    = 10,
    localparam int DEPTH = 2 ** GROUP
) (
    input  logic [GROUP-1:0]     addr_i,
    output logic signed [TW-1:0] entry_o
);
    import daf_pkg::*;

    function automatic int entry_val(input int a);
        int acc;
        acc = 0;
        for (int i = 0; i < GROUP; i++) begin
            if (((a >> i) & 1) == 1) acc += coef_at(BASE + i);
        end
        return acc;
    endfunction

    logic signed [TW-1:0] rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        assign rom[a] = TW'(entry_val(a));
    end

    assign entry_o = rom[addr_i];

    // R4: an all-zero address selects no coefficient.
    always_comb begin
        if (addr_i == '0) begin
            p_zero_entry_r4: assert (entry_o == '0);
        end
    end
endmodule

// File: rtl/daf_tapline.sv
module daf_tapline #(
    parameter int NTAPS = 8,
    parameter int BW    = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [BW-1:0]    sample_i,
    output logic [NTAPS-1:0] bits_o
);
    typedef struct {
        logic [BW-1:0] hist [NTAPS];
        logic [BW-1:0] ser  [NTAPS];
    } tl_t;

    tl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.hist[0] = sample_i;
            st_d.ser[0]  = sample_i;
            for (int k = 1; k < NTAPS; k++) begin
                st_d.hist[k] = st_q.hist[k-1];
                st_d.ser[k]  = st_q.hist[k-1];
            end
        end else if (shift_i) begin
            for (int k = 0; k < NTAPS; k++) begin
                st_d.ser[k] = st_q.ser[k] >> 1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < NTAPS; k++) begin
                st_q.hist[k] <= '0;
                st_q.ser[k]  <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_bits
        assign bits_o[k] = st_q.ser[k][0];
    end

    // R2: a load presents the new sample at the head of the serial copy.
    p_load_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.ser[0] == st_q.hist[0]));
endmodule

// File: rtl/daf_accum.sv
module daf_accum #(
    parameter int GSW = 11,
    parameter int BW  = 12,
    localparam int HW = GSW + 1,
    localparam int OW = HW + BW
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clear_i,
    input  logic                 en_i,
    input  logic                 neg_i,
    input  logic signed [GSW-1:0] part_i,
    output logic [OW-1:0]        fin_o
);
    typedef struct packed {
        logic signed [HW-1:0] hi;
        logic [BW-1:0]        lo;
    } acc_t;

    acc_t acc_d, acc_q;
    logic signed [HW:0] pext, addend, s;

    always_comb begin
        pext   = (HW+1)'(part_i);
        addend = neg_i ? -pext : pext;
        s      = {acc_q.hi[HW-1], acc_q.hi} + addend;
        fin_o  = {s[HW:1], s[0], acc_q.lo[BW-1:1]};
        acc_d  = acc_q;
        if (clear_i) begin
            acc_d = '0;
        end else if (en_i) begin
            acc_d.hi = s[HW:1];
            acc_d.lo = {s[0], acc_q.lo[BW-1:1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

    // R4: every run starts from an empty accumulator.
    p_clear_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (acc_q == '0));
endmodule

// File: rtl/daf_fir.sv
module daf_fir #(
    parameter int NTAPS = 8,
    parameter int GROUP = 4,
    parameter int BW    = 12,
    parameter int CW    = 8,
    localparam int NGRP = NTAPS / GROUP,
    localparam int TW   = CW + $clog2(GROUP),
    localparam int GSW  = CW + $clog2(NTAPS),
    localparam int OW   = GSW + 1 + BW,
    localparam int CNTW = $clog2(BW)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [BW-1:0] sample_i,
    output logic          busy_o,
    output logic          y_valid_o,
    output logic [OW-1:0] y_o
);
    typedef struct packed {
        logic            busy;
        logic            valid;
        logic [CNTW-1:0] cnt;
        logic [OW-1:0]   y;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 load, clear, en, neg;
    logic [NTAPS-1:0]     bits;
    logic signed [TW-1:0] grp [NGRP];
    logic signed [GSW-1:0] part;
    logic [OW-1:0]        fin;

    daf_tapline #(.NTAPS(NTAPS), .BW(BW)) u_tapline (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .shift_i  (en),
        .sample_i (sample_i),
        .bits_o   (bits)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        daf_subtable #(.BASE(g * GROUP), .GROUP(GROUP), .TW(TW)) u_tbl (
            .addr_i  (bits[g*GROUP +: GROUP]),
            .entry_o (grp[g])
        );
    end

    always_comb begin
        part = '0;
        for (int g = 0; g < NGRP; g++) begin
            part = part + GSW'(grp[g]);
        end
    end

    daf_accum #(.GSW(GSW), .BW(BW)) u_accum (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .en_i    (en),
        .neg_i   (neg),
        .part_i  (part),
        .fin_o   (fin)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        load        = 1'b0;
        clear       = 1'b0;
        en          = 1'b0;
        neg         = 1'b0;
        if (!ctl_q.busy) begin
            if (start_i) begin
                load       = 1'b1;
                clear      = 1'b1;
                ctl_d.busy = 1'b1;
                ctl_d.cnt  = '0;
            end
        end else begin
            en  = 1'b1;
            neg = (ctl_q.cnt == CNTW'(BW - 1));
            if (neg) begin
                ctl_d.busy  = 1'b0;
                ctl_d.valid = 1'b1;
                ctl_d.y     = fin;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign busy_o    = ctl_q.busy;
    assign y_valid_o = ctl_q.valid;
    assign y_o       = ctl_q.y;

    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    p_end_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> y_valid_o);

    p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        y_valid_o |=> !y_valid_o);

    p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ctl_q.cnt != CNTW'(BW - 1)) |=> (busy_o && !y_valid_o));

    p_y_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !y_valid_o |-> $stable(y_o));
endmodule

// File: tb/tb_daf_fir.sv
module tb_daf_fir;
    localparam int B  = 12;
    localparam int NT = 8;
    localparam int OW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [B-1:0]  sample = '0;
    logic          busy, yv;
    logic [OW-1:0] y;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int hist [NT];
    int h [NT] = '{5, -12, 37, 101, 88, -29, 14, -3};
    int lcg = 12345;

    always #5 clk = ~clk;

    daf_fir dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_i(sample),
        .busy_o(busy), .y_valid_o(yv), .y_o(y)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_y();
        int s = 0;
        for (int k = 0; k < NT; k++) s += h[k] * hist[k];
        return s;
    endfunction

    // Offer one sample at a negedge; optionally strobe a spurious start mid-run.
    task automatic send(input int x, input bit spurious);
        int n = 0;
        int exp;
        start  = 1'b1;
        sample = B'(x);
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        exp = expect_y();
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!yv && n < 40) begin
            check("R3 busy during run", busy, 1);
            if (spurious && n == 3) begin
                start  = 1'b1;
                sample = B'(-777);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R3 latency", n, B + 1);
        check("R3 busy low at valid", busy, 0);
        check(spurious ? "R5 result with ignored start" : "R4 output", $signed(y), exp);
    endtask

    initial begin
        for (int k = 0; k < NT; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 valid", yv, 0);
        check("R1 y", y, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: unit impulse reads out each coefficient
        send(1, 0);
        for (int i = 0; i < NT; i++) send(0, 0);
        // R6: most negative impulse
        send(-2048, 0);
        for (int i = 0; i < NT; i++) send(0, 0);
        // R6: saturated runs of both extremes
        for (int i = 0; i < 10; i++) send(-2048, 0);
        for (int i = 0; i < 10; i++) send(2047, 0);
        for (int i = 0; i < 16; i++) send((i % 2) ? 2047 : -2048, 0);
        // R4/R8: back-to-back pseudo-random sweep
        for (int i = 0; i < 200; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            send(((lcg >>> 8) % 4096) - 2048, 0);
        end
        // R5: strobes while busy leave history untouched
        for (int i = 0; i < 6; i++) send(100 * i - 250, 1);
        send(3, 0);

        // R7: output holds while idle
        begin
            logic [OW-1:0] held;
            held = y;
            repeat (5) @(negedge clk);
            check("R7 y held", y, held);
            check("R7 valid low", yv, 0);
            check("R1 idle not busy", busy, 0);
        end
        // R8: a strobe in the valid cycle is accepted
        send(-5, 0);
        send(7, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=%0d expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule